// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Arbiter

This block sits beside a small processor core and decides which of five interrupt sources the core should take next. The sources are two external pins, two timer overflow events and a serial-port request. Software writes a mask register, a level register and a trigger-type register through a simple write port. It can also write the latched request flags directly, so that a program can raise an interrupt without a hardware event.

The block counts a 12-clock machine cycle and takes a snapshot of the qualified requests once per cycle. At the next instruction boundary that the core signals, it presents a call request with a fixed 16-bit vector. It holds the call until the core acknowledges it. Each source has a high or low level, and a fixed polling order breaks ties within a level. The block records which levels are in service and blocks nesting of equal or lower levels. A return pulse from the core releases the innermost level.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset `callReq` is 0, `callVector` is 0, and every mask bit is clear, so pending requests raise no call.
- R2: Configuration address 0 is the mask register. A source can be called only when bit 7 (global) and its own bit are both 1. The source bits are bit 0 pin 0, bit 1 timer 0, bit 2 pin 1, bit 3 timer 1 and bit 4 serial.
- R3: The call vector for source index k is 0x0003 + 8·k. The indices are 0 pin 0, 1 timer 0, 2 pin 1, 3 timer 1 and 4 serial.
- R4: Configuration address 1 holds one level bit per source, in the same bit positions as R2, with 1 meaning high. A qualified high request wins over any low request seen in the same snapshot.
- R5: Within one level, the lower source index wins.
- R6: When a pin's trigger bit (address 2, bit 0 for pin 0 and bit 1 for pin 1) is 0, a low pin is a request that the controller does not clear. The call repeats after return while the pin stays low.
- R7: When a pin's trigger bit is 1, a high-to-low transition of the synchronized pin sets a latched flag. The acknowledge of that source's call clears the flag.
- R8: A one-clock timer overflow pulse sets a latched flag that the acknowledge of its call clears.
- R9: The serial request is a level input that the controller never clears. It is called again after return while it stays high.
- R10: A request is not called while its own level or a higher level is in service. A high request is called while only the low level is in service.
- R11: A return pulse clears the high in-service bit if it is set, otherwise the low one.
- R12: No call starts at a boundary strobe while `blockInstr` is high. A blocked request is called later if it is still pending.
- R13: A write to address 3 loads the latched flags. The flag bits are bit 0 pin 0, bit 1 timer 0, bit 2 pin 1 and bit 3 timer 1. A flag set this way raises a call exactly as a hardware event does.
- R14: Once raised, `callReq` stays high with a stable `callVector` until `callAck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 2 | Register select: 0 mask, 1 level, 2 trigger, 3 flags |
| cfgWdata | input | 8 | Write data |
| extPinN | input | 2 | External request pins, active low, asynchronous |
| tmrOvf | input | 2 | Timer overflow pulses |
| serialReq | input | 1 | Serial request level |
| instrBoundary | input | 1 | Core is at an instruction boundary |
| blockInstr | input | 1 | Current instruction is a return or writes the mask or level register |
| callAck | input | 1 | Core accepts the call |
| retPulse | input | 1 | Core executed a return-from-interrupt |
| callReq | output | 1 | Call request |
| callVector | output | 16 | Vector address of the call |
| callLevel | output | 1 | Level of the call (1 = high) |

## Verification
The hardest state to reach is the one where both in-service levels are held at once. A low timer call is acknowledged, and a high timer flag is then written in software, so that the second call pre-empts the first. With both levels held, a fresh low request must stay blocked through the first return pulse and appear only after the second. The blocked-instruction case holds `blockInstr` across several snapshots and then releases it. The held call is then left unacknowledged for many cycles to confirm that its vector stays stable.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NUM_SRC   = 5;
  localparam int NUM_EXT   = 2;
  localparam int NUM_FLAG  = 2 * NUM_EXT;
  localparam int IDX_W     = $clog2(NUM_SRC);
  localparam int VEC_W     = 16;
  localparam int CYC_LEN   = 12;
  localparam int SAMPLE_PH = 9;
  localparam int VEC_BASE  = 3;
  localparam int VEC_STEP  = 8;
  localparam int GLOBAL_BIT = 7;

  typedef enum logic [1:0] {
    REG_MASK  = 2'd0,
    REG_LEVEL = 2'd1,
    REG_TRIG  = 2'd2,
    REG_FLAGS = 2'd3
  } cfgReg_e;

  typedef struct packed {
    logic                sample;
    logic                clrSnap;
    logic [NUM_FLAG-1:0] clrFlag;
  } ctrlStrobe_t;
endpackage

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic [1:0]          cfgAddr,
  input  logic [7:0]          cfgWdata,
  input  logic [NUM_EXT-1:0]  extPinN,
  input  logic [NUM_EXT-1:0]  tmrOvf,
  input  logic                serialReq,
  input  ctrlStrobe_t         strobe,
  output logic                winValid,
  output logic [IDX_W-1:0]    winIdx,
  output logic                winHigh
);
  logic [7:0]          maskReg;
  logic [NUM_SRC-1:0]  levelReg;
  logic [NUM_EXT-1:0]  trigReg;
  logic [NUM_FLAG-1:0] flags;
  logic [NUM_FLAG-1:0] hwSet;
  logic [NUM_SRC-1:0]  reqVec;
  logic [NUM_SRC-1:0]  snapReq;
  logic [NUM_SRC-1:0]  snapLevel;
  logic [NUM_EXT-1:0]  syncA, syncB, syncPrev, fallSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg  <= '0;
      levelReg <= '0;
      trigReg  <= '0;
    end else if (cfgWe) begin
      case (cfgReg_e'(cfgAddr))
        REG_MASK:  maskReg  <= cfgWdata;
        REG_LEVEL: levelReg <= cfgWdata[NUM_SRC-1:0];
        REG_TRIG:  trigReg  <= cfgWdata[NUM_EXT-1:0];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_EXT; g++) begin : gExt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA[g]    <= 1'b1;
        syncB[g]    <= 1'b1;
        syncPrev[g] <= 1'b1;
      end else begin
        syncA[g]    <= extPinN[g];
        syncB[g]    <= syncA[g];
        syncPrev[g] <= syncB[g];
      end
    end
    assign fallSeen[g]    = syncPrev[g] & ~syncB[g];
    assign hwSet[2*g]     = trigReg[g] & fallSeen[g];
    assign hwSet[2*g+1]   = tmrOvf[g];
    assign reqVec[2*g]    = flags[2*g] | (~trigReg[g] & ~syncB[g]);
    assign reqVec[2*g+1]  = flags[2*g+1];

    assert_edge_latch_R7: assert property (@(posedge clk) disable iff (!rstN)
      (trigReg[g] && fallSeen[g]) |=> flags[2*g]);
    assert_timer_latch_R8: assert property (@(posedge clk) disable iff (!rstN)
      tmrOvf[g] |=> flags[2*g+1]);
  end
  assign reqVec[NUM_SRC-1] = serialReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags <= '0;
    end else begin
      if (cfgWe && cfgReg_e'(cfgAddr) == REG_FLAGS)
        flags <= cfgWdata[NUM_FLAG-1:0] | hwSet;
      else
        flags <= (flags & ~strobe.clrFlag) | hwSet;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snapReq   <= '0;
      snapLevel <= '0;
    end else if (strobe.clrSnap) begin
      snapReq   <= '0;
    end else if (strobe.sample) begin
      snapReq   <= reqVec & maskReg[NUM_SRC-1:0] & {NUM_SRC{maskReg[GLOBAL_BIT]}};
      snapLevel <= levelReg;
    end
  end

  function automatic logic [IDX_W-1:0] firstSet(input logic [NUM_SRC-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  logic [NUM_SRC-1:0] hiSet, loSet;
  always_comb begin
    hiSet    = snapReq & snapLevel;
    loSet    = snapReq & ~snapLevel;
    winValid = |snapReq;
    winHigh  = |hiSet;
    winIdx   = (|hiSet) ? firstSet(hiSet) : firstSet(loSet);
  end

  assert_snap_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.sample && !strobe.clrSnap) |=> $stable(snapReq));
  assert_no_global_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sample && !strobe.clrSnap && !maskReg[GLOBAL_BIT]) |=> !winValid);
endmodule

// File: rtl/irqc_control.sv
module irqc_control
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             instrBoundary,
  input  logic             blockInstr,
  input  logic             callAck,
  input  logic             retPulse,
  input  logic             winValid,
  input  logic [IDX_W-1:0] winIdx,
  input  logic             winHigh,
  output ctrlStrobe_t      strobe,
  output logic             callReq,
  output logic [VEC_W-1:0] callVector,
  output logic             callLevel
);
  localparam int PH_W = $clog2(CYC_LEN);

  logic [PH_W-1:0]  phase;
  logic [IDX_W-1:0] callIdx;
  logic             inSvcHigh, inSvcLow;
  logic             levelBlocked, startCall, ackNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= '0;
    else if (phase == PH_W'(CYC_LEN - 1)) phase <= '0;
    else phase <= phase + 1'b1;
  end

  assign levelBlocked = inSvcHigh | (inSvcLow & ~winHigh);
  assign startCall    = !callReq && instrBoundary && !blockInstr && winValid && !levelBlocked;
  assign ackNow       = callReq && callAck;

  always_comb begin
    strobe.sample  = (phase == PH_W'(SAMPLE_PH));
    strobe.clrSnap = ackNow;
    strobe.clrFlag = '0;
    if (ackNow && callIdx < IDX_W'(NUM_FLAG))
      strobe.clrFlag[callIdx[$clog2(NUM_FLAG)-1:0]] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      callReq   <= 1'b0;
      callIdx   <= '0;
      callLevel <= 1'b0;
    end else if (ackNow) begin
      callReq   <= 1'b0;
    end else if (startCall) begin
      callReq   <= 1'b1;
      callIdx   <= winIdx;
      callLevel <= winHigh;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inSvcHigh <= 1'b0;
      inSvcLow  <= 1'b0;
    end else if (ackNow) begin
      if (callLevel) inSvcHigh <= 1'b1;
      else           inSvcLow  <= 1'b1;
    end else if (retPulse) begin
      if (inSvcHigh) inSvcHigh <= 1'b0;
      else           inSvcLow  <= 1'b0;
    end
  end

  assign callVector = callReq ? (VEC_W'(VEC_BASE) + VEC_W'(callIdx) * VEC_W'(VEC_STEP)) : '0;

  assert_hold_until_ack_R14: assert property (@(posedge clk) disable iff (!rstN)
    (callReq && !callAck) |=> (callReq && $stable(callVector)));
  assert_start_at_boundary_R12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(callReq) |-> ($past(instrBoundary) && !$past(blockInstr)));
  assert_high_ack_marks_R10: assert property (@(posedge clk) disable iff (!rstN)
    (callReq && callAck && callLevel) |=> inSvcHigh);
  assert_return_high_first_R11: assert property (@(posedge clk) disable iff (!rstN)
    (retPulse && !ackNow && inSvcHigh) |=> (!inSvcHigh && inSvcLow == $past(inSvcLow)));
  assert_vector_align_R3: assert property (@(posedge clk) disable iff (!rstN)
    callReq |-> (callVector[2:0] == 3'd3));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irqc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWe,
  input  logic [1:0]  cfgAddr,
  input  logic [7:0]  cfgWdata,
  input  logic [1:0]  extPinN,
  input  logic [1:0]  tmrOvf,
  input  logic        serialReq,
  input  logic        instrBoundary,
  input  logic        blockInstr,
  input  logic        callAck,
  input  logic        retPulse,
  output logic        callReq,
  output logic [15:0] callVector,
  output logic        callLevel
);
  ctrlStrobe_t      strobe;
  logic             winValid, winHigh;
  logic [IDX_W-1:0] winIdx;

  irqc_datapath uDp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .extPinN(extPinN), .tmrOvf(tmrOvf), .serialReq(serialReq), .strobe(strobe),
    .winValid(winValid), .winIdx(winIdx), .winHigh(winHigh)
  );

  irqc_control uCtl (
    .clk(clk), .rstN(rstN), .instrBoundary(instrBoundary), .blockInstr(blockInstr),
    .callAck(callAck), .retPulse(retPulse), .winValid(winValid), .winIdx(winIdx),
    .winHigh(winHigh), .strobe(strobe), .callReq(callReq), .callVector(callVector),
    .callLevel(callLevel)
  );

  assert_idle_vector_R1: assert property (@(posedge clk) disable iff (!rstN)
    !callReq |-> (callVector == 16'h0000));
endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [1:0] cfgAddr = '0;
  logic [7:0] cfgWdata = '0;
  logic [1:0] extPinN = 2'b11;
  logic [1:0] tmrOvf = '0;
  logic serialReq = 1'b0;
  logic instrBoundary = 1'b1;
  logic blockInstr = 1'b0;
  logic callAck = 1'b0;
  logic retPulse = 1'b0;
  logic callReq, callLevel;
  logic [15:0] callVector;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .extPinN(extPinN), .tmrOvf(tmrOvf), .serialReq(serialReq),
    .instrBoundary(instrBoundary), .blockInstr(blockInstr), .callAck(callAck),
    .retPulse(retPulse), .callReq(callReq), .callVector(callVector), .callLevel(callLevel)
  );

  // {mask, 3'b0, level, 3'b0, serial, flags, expValid, 1'b0, expVec}
  localparam logic [31:0] TBL [9] = '{
    {8'h00, 3'b0, 5'h00, 3'b0, 1'b1, 4'hF, 1'b0, 1'b0, 6'h00},  // R1 masked
    {8'h1F, 3'b0, 5'h00, 3'b0, 1'b1, 4'hF, 1'b0, 1'b0, 6'h00},  // R2 no global
    {8'h9F, 3'b0, 5'h00, 3'b0, 1'b1, 4'hF, 1'b1, 1'b0, 6'h03},  // R5 order
    {8'h9E, 3'b0, 5'h00, 3'b0, 1'b1, 4'hF, 1'b1, 1'b0, 6'h0B},  // R2 R5
    {8'h9F, 3'b0, 5'h10, 3'b0, 1'b1, 4'hF, 1'b1, 1'b0, 6'h23},  // R4 serial high
    {8'h9F, 3'b0, 5'h0A, 3'b0, 1'b0, 4'hF, 1'b1, 1'b0, 6'h0B},  // R4 R5 high tie
    {8'h98, 3'b0, 5'h00, 3'b0, 1'b1, 4'hF, 1'b1, 1'b0, 6'h1B},  // R3 timer 1
    {8'h84, 3'b0, 5'h00, 3'b0, 1'b0, 4'h4, 1'b1, 1'b0, 6'h13},  // R3 R13 pin 1
    {8'h90, 3'b0, 5'h00, 3'b0, 1'b0, 4'hF, 1'b0, 1'b0, 6'h00}   // R2 serial off
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; extPinN = 2'b11; tmrOvf = '0; serialReq = 1'b0;
    blockInstr = 1'b0; callAck = 1'b0; retPulse = 1'b0; instrBoundary = 1'b1; cfgWe = 1'b0;
    tick(3);
    rstN = 1'b1;
    tick(1);
  endtask

  task automatic cfgWrite(input logic [1:0] a, input logic [7:0] d);
    cfgAddr = a; cfgWdata = d; cfgWe = 1'b1;
    tick(1);
    cfgWe = 1'b0;
  endtask

  task automatic ack();
    callAck = 1'b1; tick(1); callAck = 1'b0; tick(1);
  endtask

  task automatic ret();
    retPulse = 1'b1; tick(1); retPulse = 1'b0; tick(1);
  endtask

  task automatic expectCall(input string tag, input int vec);
    check(callReq === 1'b1 && callVector == 16'(vec), tag, {callReq, callVector}, {1'b1, 16'(vec)});
  endtask

  task automatic expectNone(input string tag);
    check(callReq === 1'b0, tag, callReq, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R14 watchdog expired actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    doReset();
    check(callReq === 1'b0 && callVector == 16'h0, "R1 reset", {callReq, callVector}, 0);

    for (int i = 0; i < 9; i++) begin
      doReset();
      cfgWrite(2'd0, TBL[i][31:24]);
      cfgWrite(2'd1, {3'b0, TBL[i][20:16]});
      cfgWrite(2'd3, {4'b0, TBL[i][11:8]});
      serialReq = TBL[i][12];
      tick(30);
      if (TBL[i][7]) expectCall($sformatf("R3 R4 R5 table row %0d", i), int'(TBL[i][5:0]));
      else expectNone($sformatf("R1 R2 table row %0d", i));
    end

    // R7 edge trigger, flag cleared on ack
    doReset();
    cfgWrite(2'd2, 8'h01);
    cfgWrite(2'd0, 8'h81);
    extPinN[0] = 1'b0;
    tick(30);
    expectCall("R7 edge call", 16'h0003);
    ack(); ret(); tick(30);
    expectNone("R7 edge flag cleared");

    // R6 level trigger persists
    doReset();
    cfgWrite(2'd0, 8'h81);
    extPinN[0] = 1'b0;
    tick(30);
    expectCall("R6 level call", 16'h0003);
    ack(); ret(); tick(30);
    expectCall("R6 level repeats", 16'h0003);

    // R8 timer overflow pulse
    doReset();
    cfgWrite(2'd0, 8'h82);
    tmrOvf[0] = 1'b1; tick(1); tmrOvf[0] = 1'b0;
    tick(30);
    expectCall("R8 timer call", 16'h000B);
    ack(); ret(); tick(30);
    expectNone("R8 timer flag cleared");

    // R9 serial not cleared
    doReset();
    cfgWrite(2'd0, 8'h90);
    serialReq = 1'b1;
    tick(30);
    expectCall("R9 serial call", 16'h0023);
    ack(); ret(); tick(30);
    expectCall("R9 serial repeats", 16'h0023);
    serialReq = 1'b0;
    ack(); ret(); tick(30);
    expectNone("R9 serial dropped");

    // R10 R11 nesting
    doReset();
    cfgWrite(2'd0, 8'h8A);
    cfgWrite(2'd1, 8'h08);
    cfgWrite(2'd3, 8'h02);
    tick(30);
    expectCall("R10 low call", 16'h000B);
    check(callLevel === 1'b0, "R10 low level", callLevel, 0);
    ack();
    cfgWrite(2'd3, 8'h08);
    tick(30);
    expectCall("R10 high preempts low", 16'h001B);
    ack();
    cfgWrite(2'd3, 8'h02);
    tick(30);
    expectNone("R10 low blocked while nested");
    ret(); tick(30);
    expectNone("R11 first return frees high only");
    ret(); tick(30);
    expectCall("R11 second return frees low", 16'h000B);

    // R12 blocking instruction, R14 hold
    doReset();
    cfgWrite(2'd0, 8'h82);
    blockInstr = 1'b1;
    cfgWrite(2'd3, 8'h02);
    tick(30);
    expectNone("R12 blocked by instruction");
    blockInstr = 1'b0;
    tick(30);
    expectCall("R12 taken after block", 16'h000B);
    tick(40);
    expectCall("R14 held without ack", 16'h000B);
    ack();
    expectNone("R14 dropped after ack");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule